// File: doc/BRIEF.md
# HMAC-SHA256 Inner Hash Sequencer

This block drives the inner half of an HMAC-SHA256 computation through one external SHA-256 compression engine. When a 512-bit key is loaded, the sequencer XORs every key byte with the inner pad value 0x36. It sends that block to the engine, seeded with the standard SHA-256 initial hash. The chaining value that comes back is kept as the key state. Message blocks then arrive over a valid/ready handshake. The first block is seeded from the key state, and each later block is seeded from the result of the block before it. When the block flagged as last has been compressed, its result is presented as the inner digest together with a one-cycle strobe.

The caller supplies message blocks that already carry SHA-256 padding. The outer (opad) hash, shortening of long keys, and the compression function itself all belong to other logic. The saved key state outlives a message. Further messages under the same key can therefore start straight from idle, without compressing the key block again.

Top module: `hmac_inner_seq`

## Requirements
- R1: After reset, `msg_ready`, `cmp_start` and `digest_valid` are low, and no key state is held: `msg_ready` stays low until a key has been compressed.
- R2: A `key_load` accepted in idle issues one compression whose block is `key_in` with each byte XORed with 0x36, and whose seed is the SHA-256 initial hash with 6a09e667 in bits [255:224] down to 5be0cd19 in bits [31:0]. `cmp_start` goes high in the cycle after `key_load`.
- R3: The result returned for the key block is saved as the key state. The first message block after a key load is issued with that value as its seed.
- R4: Each message block after the first in the same message is seeded with the result of the previous compression.
- R5: When the compression of a block with `msg_last` set completes, `digest` takes that result and `digest_valid` pulses for exactly one cycle, in the cycle after `cmp_done`. The sequencer then returns to idle.
- R6: Each issue is a single-cycle `cmp_start` pulse. `cmp_block` and `cmp_seed` hold steady until `cmp_done`. A block accepted by `msg_valid && msg_ready` is issued in the next cycle.
- R7: In idle, once a key state exists, `msg_ready` is high and a new message may start without reloading the key; its first block is seeded with the saved key state. A `key_load` in idle takes priority and drops `msg_ready` in that cycle.
- R8: A `key_load` that arrives while a message is in progress or a compression is running is ignored. The saved key state and the digest in progress are unchanged.
- R9: `msg_ready` is low while any compression is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_load | input | 1 | Load `key_in` as a new key (acted on only in idle) |
| key_in | input | 512 | Key block, already 64 bytes |
| msg_valid | input | 1 | Message block offered |
| msg_ready | output | 1 | Sequencer takes the offered block this cycle |
| msg_block | input | 512 | Padded message block |
| msg_last | input | 1 | Offered block is the final one of the message |
| cmp_start | output | 1 | One-cycle request to the compression engine |
| cmp_block | output | 512 | Block for the engine, held while it runs |
| cmp_seed | output | 256 | Chaining input for the engine, held while it runs |
| cmp_done | input | 1 | Engine finished; `cmp_result` valid this cycle |
| cmp_result | input | 256 | Engine output chaining value |
| digest_valid | output | 1 | One-cycle strobe marking a new inner digest |
| digest | output | 256 | Inner digest of the last completed message |

## Verification
The bench checks that the first message block after a key is seeded from the key result and not from the initial hash or from the previous message's tail. A design that got this wrong would produce a digest that is valid-looking but wrong. It starts a second message under the same key, with no reload, to catch a design that forgets the key state or that reuses the last chaining value. It pulses `key_load` in the middle of a message; a design that honoured it would corrupt both the current digest and the next keyless message. The engine model varies its latency, so a design that drops its held block or seed, or issues twice, is exposed.

// File: rtl/hmac_seq_pkg.sv
package hmac_seq_pkg;

    localparam int unsigned BLOCK_BITS = 512;
    localparam int unsigned STATE_BITS = 256;
    localparam logic [7:0]  IPAD_BYTE  = 8'h36;

    // SHA-256 initial hash, word 0 in the top bits
    localparam logic [255:0] SHA256_IV = {
        32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
        32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
    };

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_KEY_RUN = 2'd1,
        SQ_ACCEPT  = 2'd2,
        SQ_MSG_RUN = 2'd3
    } seq_state_e;

endpackage

// File: rtl/hmac_ipad_mix.sv
module hmac_ipad_mix #(
    parameter int unsigned BLK_W    = 512,
    parameter logic [7:0]  PAD_BYTE = 8'h36
) (
    input  logic [BLK_W-1:0] key_raw,
    output logic [BLK_W-1:0] key_padded
);
    localparam int unsigned NUM_BYTES = BLK_W / 8;

    for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_byte
        assign key_padded[gi*8 +: 8] = key_raw[gi*8 +: 8] ^ PAD_BYTE;
    end

endmodule

// File: rtl/hmac_key_state.sv
module hmac_key_state #(
    parameter int unsigned ST_W = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [ST_W-1:0] cv_in,
    output logic [ST_W-1:0] cv_out,
    output logic            cv_valid
);
    typedef struct packed {
        logic [ST_W-1:0] cv;
        logic            valid;
    } ks_t;

    ks_t ks_d, ks_q;

    always_comb begin
        ks_d = ks_q;
        if (capture) begin
            ks_d.cv    = cv_in;
            ks_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ks_q <= '0;
        end else begin
            ks_q <= ks_d;
        end
    end

    assign cv_out   = ks_q.cv;
    assign cv_valid = ks_q.valid;

    AST_KEEP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cv_valid |=> cv_valid); // R3

    AST_CAPTURE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (cv_out == $past(cv_in))); // R3

endmodule

// File: rtl/hmac_inner_seq.sv
module hmac_inner_seq
    import hmac_seq_pkg::*;
#(
    parameter int unsigned BLK_W    = BLOCK_BITS,
    parameter int unsigned ST_W     = STATE_BITS,
    parameter logic [7:0]  PAD_BYTE = IPAD_BYTE,
    parameter logic [255:0] IV      = SHA256_IV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_load,
    input  logic [BLK_W-1:0] key_in,
    input  logic             msg_valid,
    output logic             msg_ready,
    input  logic [BLK_W-1:0] msg_block,
    input  logic             msg_last,
    output logic             cmp_start,
    output logic [BLK_W-1:0] cmp_block,
    output logic [ST_W-1:0]  cmp_seed,
    input  logic             cmp_done,
    input  logic [ST_W-1:0]  cmp_result,
    output logic             digest_valid,
    output logic [ST_W-1:0]  digest
);
    localparam logic [ST_W-1:0] IV_C = ST_W'(IV);

    typedef struct packed {
        seq_state_e       st;
        logic [BLK_W-1:0] blk;
        logic [ST_W-1:0]  seed;
        logic             start;
        logic             last;
        logic [ST_W-1:0]  dig;
        logic             dvalid;
    } seq_t;

    seq_t cs_q, cs_d;

    logic [BLK_W-1:0] key_mixed;
    logic [ST_W-1:0]  key_cv;
    logic             key_ok;
    logic             key_cap;

    hmac_ipad_mix #(
        .BLK_W    (BLK_W),
        .PAD_BYTE (PAD_BYTE)
    ) u_mix (
        .key_raw    (key_in),
        .key_padded (key_mixed)
    );

    hmac_key_state #(
        .ST_W (ST_W)
    ) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (key_cap),
        .cv_in    (cmp_result),
        .cv_out   (key_cv),
        .cv_valid (key_ok)
    );

    // done in the same cycle as the start pulse belongs to no issue
    logic done_ok;
    assign done_ok = cmp_done && !cs_q.start;

    always_comb begin
        cs_d        = cs_q;
        cs_d.start  = 1'b0;
        cs_d.dvalid = 1'b0;
        key_cap     = 1'b0;
        msg_ready   = 1'b0;

        case (cs_q.st)
            SQ_IDLE: begin
                msg_ready = key_ok && !key_load;
                if (key_load) begin
                    cs_d.blk   = key_mixed;
                    cs_d.seed  = IV_C;
                    cs_d.start = 1'b1;
                    cs_d.st    = SQ_KEY_RUN;
                end else if (msg_valid && key_ok) begin
                    cs_d.blk   = msg_block;
                    cs_d.last  = msg_last;
                    cs_d.seed  = key_cv;
                    cs_d.start = 1'b1;
                    cs_d.st    = SQ_MSG_RUN;
                end
            end
            SQ_KEY_RUN: begin
                if (done_ok) begin
                    key_cap   = 1'b1;
                    cs_d.seed = cmp_result;
                    cs_d.st   = SQ_ACCEPT;
                end
            end
            SQ_ACCEPT: begin
                msg_ready = 1'b1;
                if (msg_valid) begin
                    cs_d.blk   = msg_block;
                    cs_d.last  = msg_last;
                    cs_d.start = 1'b1;
                    cs_d.st    = SQ_MSG_RUN;
                end
            end
            SQ_MSG_RUN: begin
                if (done_ok) begin
                    if (cs_q.last) begin
                        cs_d.dig    = cmp_result;
                        cs_d.dvalid = 1'b1;
                        cs_d.st     = SQ_IDLE;
                    end else begin
                        cs_d.seed = cmp_result;
                        cs_d.st   = SQ_ACCEPT;
                    end
                end
            end
            default: cs_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign cmp_start    = cs_q.start;
    assign cmp_block    = cs_q.blk;
    assign cmp_seed     = cs_q.seed;
    assign digest_valid = cs_q.dvalid;
    assign digest       = cs_q.dig;

    logic running;
    assign running = (cs_q.st == SQ_KEY_RUN) || (cs_q.st == SQ_MSG_RUN);

    AST_KEY_FIRST_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (key_load && cs_q.st == SQ_IDLE) |=> (cmp_start && cmp_seed == IV_C)); // R2

    AST_DIGEST_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        digest_valid |-> ($past(cmp_done) && digest == $past(cmp_result))); // R5

    AST_DIGEST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        digest_valid |=> !digest_valid); // R5

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_start |=> !cmp_start); // R6

    AST_ISSUE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cmp_start) |-> ($stable(cmp_block) && $stable(cmp_seed))); // R6

    AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> cmp_start); // R6

    AST_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (key_load && (cs_q.st == SQ_ACCEPT || cs_q.st == SQ_MSG_RUN)) |=> $stable(key_cv)); // R8

    AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_start |-> !msg_ready); // R9

endmodule

// File: tb/hmac_inner_seq_test.sv
`timescale 1ns/1ps
module hmac_inner_seq_test;

    localparam logic [255:0] IV = {
        32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
        32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         key_load = 1'b0;
    logic [511:0] key_in = '0;
    logic         msg_valid = 1'b0;
    logic         msg_ready;
    logic [511:0] msg_block = '0;
    logic         msg_last = 1'b0;
    logic         cmp_start;
    logic [511:0] cmp_block;
    logic [255:0] cmp_seed;
    logic         cmp_done = 1'b0;
    logic [255:0] cmp_result = '0;
    logic         digest_valid;
    logic [255:0] digest;

    hmac_inner_seq uut (
        .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_block(msg_block),
        .msg_last(msg_last), .cmp_start(cmp_start), .cmp_block(cmp_block),
        .cmp_seed(cmp_seed), .cmp_done(cmp_done), .cmp_result(cmp_result),
        .digest_valid(digest_valid), .digest(digest)
    );

    int checks = 0;
    int fails  = 0;
    bit reported = 0;

    logic [511:0] exp_blk_q[$];
    logic [255:0] exp_seed_q[$];
    string        exp_tag_q[$];
    logic [255:0] exp_dig_q[$];
    logic [255:0] model_key_cv;

    task automatic check(input bit ok, input string tag,
                         input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
    endtask

    function automatic logic [255:0] engine(input logic [255:0] s, input logic [511:0] b);
        logic [255:0] r;
        for (int w = 0; w < 8; w++) begin
            logic [31:0] sw;
            sw = s[255-32*w -: 32];
            r[255-32*w -: 32] = {sw[26:0], sw[31:27]}
                + (b[511-32*w -: 32] ^ b[255-32*w -: 32])
                + (32'(w + 1) * 32'h7f4a7c15);
        end
        return r;
    endfunction

    function automatic logic [511:0] ipad(input logic [511:0] k);
        return k ^ {64{8'h36}};
    endfunction

    function automatic logic [511:0] make_blk(input int base, input int idx);
        logic [511:0] b;
        for (int w = 0; w < 16; w++)
            b[511-32*w -: 32] = (32'(base) * 32'h01010101) ^ (32'(idx) << 8)
                                ^ (32'(w) * 32'h9e3779b9);
        return b;
    endfunction

    // engine model: checks each issue against the scoreboard, varies latency
    int n_issue = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (cmp_start) begin
                logic [511:0] b;
                logic [255:0] s;
                int lat;
                b = cmp_block;
                s = cmp_seed;
                if (exp_blk_q.size() == 0) begin
                    check(0, "R6 unexpected issue", {256'b0, s}, '0);
                end else begin
                    logic [511:0] eb;
                    logic [255:0] es;
                    string tg;
                    eb = exp_blk_q.pop_front();
                    es = exp_seed_q.pop_front();
                    tg = exp_tag_q.pop_front();
                    check(b == eb, {tg, " block"}, b, eb);
                    check(s == es, {tg, " seed"}, {256'b0, s}, {256'b0, es});
                end
                lat = 1 + (n_issue % 4);
                n_issue++;
                repeat (lat) @(negedge clk);
                check(cmp_block == b && cmp_seed == s, "R6 held operands",
                      cmp_block, b);
                cmp_result = engine(s, b);
                cmp_done   = 1'b1;
                @(negedge clk);
                cmp_done   = 1'b0;
            end
        end
    end

    // digest monitor
    initial begin
        forever begin
            @(negedge clk);
            if (digest_valid) begin
                if (exp_dig_q.size() == 0) begin
                    check(0, "R5 unexpected digest", {256'b0, digest}, '0);
                end else begin
                    logic [255:0] ed;
                    ed = exp_dig_q.pop_front();
                    check(digest == ed, "R5 digest", {256'b0, digest}, {256'b0, ed});
                end
            end
        end
    end

    task automatic load_key(input logic [511:0] k, input bit have_key);
        @(negedge clk);
        key_in   = k;
        key_load = 1'b1;
        exp_blk_q.push_back(ipad(k));
        exp_seed_q.push_back(IV);
        exp_tag_q.push_back("R2");
        model_key_cv = engine(IV, ipad(k));
        #1;
        if (have_key)
            check(msg_ready == 1'b0, "R7 key priority over ready",
                  {511'b0, msg_ready}, '0);
        @(negedge clk);
        key_load = 1'b0;
        check(cmp_start == 1'b1, "R2 start after key_load", {511'b0, cmp_start}, 512'd1);
        check(msg_ready == 1'b0, "R9 ready low during key run",
              {511'b0, msg_ready}, '0);
    endtask

    task automatic run_msg(input int base, input int n, input string first_tag);
        logic [255:0] h;
        h = model_key_cv;
        for (int i = 0; i < n; i++) begin
            logic [511:0] b;
            b = make_blk(base, i);
            exp_blk_q.push_back(b);
            exp_seed_q.push_back(h);
            exp_tag_q.push_back(i == 0 ? first_tag : "R4");
            h = engine(h, b);
        end
        exp_dig_q.push_back(h);
        for (int i = 0; i < n; i++) begin
            msg_valid = 1'b1;
            msg_block = make_blk(base, i);
            msg_last  = (i == n - 1);
            while (!msg_ready) @(negedge clk);
            @(negedge clk);
            msg_valid = 1'b0;
            msg_last  = 1'b0;
            check(msg_ready == 1'b0, "R9 ready low after accept",
                  {511'b0, msg_ready}, '0);
        end
    endtask

    task automatic wait_idle();
        while (exp_dig_q.size() != 0 || exp_blk_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog expired", '0, 512'd1);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(msg_ready == 1'b0, "R1 ready after reset", {511'b0, msg_ready}, '0);
        check(cmp_start == 1'b0, "R1 start after reset", {511'b0, cmp_start}, '0);
        check(digest_valid == 1'b0, "R1 strobe after reset", {511'b0, digest_valid}, '0);
        msg_valid = 1'b1;
        msg_block = make_blk(99, 0);
        msg_last  = 1'b1;
        repeat (3) @(negedge clk);
        check(cmp_start == 1'b0, "R1 no message before key", {511'b0, cmp_start}, '0);
        msg_valid = 1'b0;
        msg_last  = 1'b0;

        // key then single-block message
        load_key(make_blk(7, 40), 1'b0);
        run_msg(1, 1, "R3");
        wait_idle();

        // key-less message under the same key, three blocks
        run_msg(2, 3, "R7");
        wait_idle();

        // key_load in the middle of a message is ignored
        fork
            run_msg(3, 2, "R7");
            begin
                repeat (3) @(negedge clk);
                key_in   = make_blk(55, 55);
                key_load = 1'b1;
                @(negedge clk);
                key_load = 1'b0;
            end
        join
        wait_idle();
        run_msg(4, 1, "R8");
        wait_idle();

        // new key replaces the old one, two-block message
        load_key(make_blk(11, 12), 1'b1);
        run_msg(5, 2, "R3");
        wait_idle();
        check(digest_valid == 1'b0, "R5 strobe single cycle", {511'b0, digest_valid}, '0);

        report();
        $finish;
    end

endmodule